// File: doc/BRIEF.md
# External bus strobe generator

This block produces the two timing strobes of an 8051-style multiplexed external memory bus: the address-latch enable (ALE, active high) and the program-store enable (PSEN, active low). A twelve-phase counter runs on the oscillator clock. It splits each machine cycle into six states of two phases each. ALE pulses for one state in each half of the cycle. PSEN, when code runs from external memory, is driven low for the state that follows each ALE pulse.

The rest of the core supplies three flags: one that marks a machine cycle as an external data transfer, one that marks a code-table read, and one that says the program runs from external memory. An external data transfer takes over the bus for part of the cycle. The generator therefore drops the first ALE pulse and both PSEN pulses of that cycle.

A write port loads a one-bit ALE-disable control. While that bit is set, ALE stays high unless the cycle is a data transfer or a code-table read. When the core runs from external memory, the bit has no effect. All flags and the disable bit are latched once per machine cycle, so a cycle's strobe pattern never changes partway through.

Top module: `ext_bus_strobe`

## Requirements
- R1: After reset is released, the k-th rising clock edge (k >= 1) puts the strobes at phase (k-1) mod 12 of a machine cycle. A machine cycle is 12 phases, grouped as six states of two phases.
- R2: With ALE enabled and no data transfer, `ale_o` is 1 in phases 0, 1, 6 and 7 and 0 in every other phase.
- R3: With external execution and no data transfer, `psen_n_o` is 0 in phases 2, 3, 8 and 9 and 1 in every other phase. ALE and PSEN are never active in the same phase.
- R4: When code executes from internal memory (`ext_exec_i` = 0), `psen_n_o` stays 1 for the whole cycle.
- R5: In a data-transfer cycle (`xdata_cyc_i` = 1), the ALE pulse of phases 0 and 1 is suppressed (`ale_o` = 0) and the pulse of phases 6 and 7 remains. `psen_n_o` stays 1 for the whole cycle.
- R6: A write with `reg_we_i` = 1 and `reg_addr_i` = 0x8E loads `reg_wdata_i` bit 0 into the ALE-disable bit (1 = disabled). A write to any other address leaves the bit unchanged.
- R7: With the disable bit set, and with no data transfer, no code-table read and no external execution, `ale_o` is held at 1 for the whole cycle.
- R8: With the disable bit set, a code-table read cycle pulses ALE as in R2, and a data-transfer cycle pulses ALE as in R5.
- R9: With the disable bit set and external execution active, ALE pulses exactly as in R2.
- R10: The three flags and the disable bit are sampled only at the edge that ends phase 11, which is edge k with k a multiple of 12. The values at that edge govern the whole next cycle, and a change inside a cycle does not alter that cycle's strobes.
- R11: While `rst` is high, `ale_o` is 0 and `psen_n_o` is 1. Reset clears the ALE-disable bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per cycle |
| rst | input | 1 | Synchronous reset, active high |
| xdata_cyc_i | input | 1 | Current machine cycle is an external data transfer |
| code_rd_i | input | 1 | Current machine cycle is a code-table read |
| ext_exec_i | input | 1 | Program executes from external memory |
| reg_we_i | input | 1 | Control register write strobe |
| reg_addr_i | input | 8 | Control register write address |
| reg_wdata_i | input | 8 | Control register write data |
| ale_o | output | 1 | Address-latch enable, active high |
| psen_n_o | output | 1 | Program-store enable, active low |

## Verification
The assertions assume that the bus flags are settled by the edge that ends a machine cycle. They compare each cycle's strobes with the context latched at that edge, not with the live pins. The stimulus meets this assumption: each scenario task sets its flags on a falling edge, waits for the next boundary edge, and keeps the flags steady for the whole cycle it checks. The one exception is the mid-cycle test, which changes the flags on purpose and then expects no effect. Control writes are finished before the boundary that should pick them up, so the disable bit the bench tracks matches the one latched into the cycle.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

    // Context captured once per machine cycle; drives the whole cycle's strobes.
    typedef struct packed {
        logic xdata;     // external data transfer cycle
        logic code_rd;   // code-table read cycle
        logic ext_exec;  // executing from external memory
        logic ale_off;   // ALE-disable control bit
    } cyc_ctx_t;

    localparam cyc_ctx_t CTX_RESET = '{xdata: 1'b0, code_rd: 1'b0, ext_exec: 1'b0, ale_off: 1'b0};

    // Kind of slot a given phase belongs to.
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_ALE  = 2'd1,
        SLOT_PSEN = 2'd2
    } slot_e;

    // ALE may toggle unless it is disabled and nothing overrides the disable.
    function automatic logic ale_allowed(cyc_ctx_t c);
        return !c.ale_off || c.ext_exec || c.xdata || c.code_rd;
    endfunction

    // PSEN strobes only while fetching externally and the bus is not lent to data.
    function automatic logic psen_allowed(cyc_ctx_t c);
        return c.ext_exec && !c.xdata;
    endfunction

    // Slot kind of a state: first state of each half is ALE, the next is PSEN.
    function automatic slot_e slot_of_state(int unsigned st, int unsigned half);
        if (st == 0 || st == half)
            return SLOT_ALE;
        else if (st == 1 || st == half + 1)
            return SLOT_PSEN;
        else
            return SLOT_IDLE;
    endfunction

endpackage

// File: rtl/bstb_phase_ctr.sv
module bstb_phase_ctr #(
    parameter int unsigned PHASES = 12,
    parameter int unsigned PH_W   = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase_o,
    output logic            cyc_end_o
);
    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    logic [PH_W-1:0] phase_q;

    assign cyc_end_o = (phase_q == LAST);
    assign phase_o   = phase_q;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (cyc_end_o)
            phase_q <= '0;
        else
            phase_q <= phase_q + PH_W'(1);
    end

    // R1: the counter wraps after the last phase and otherwise steps by one
    p_phase_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        cyc_end_o |=> (phase_q == '0));
    p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
        !cyc_end_o |=> (phase_q == $past(phase_q) + PH_W'(1)));

endmodule

// File: rtl/bstb_ctrl_reg.sv
module bstb_ctrl_reg #(
    parameter int unsigned          ADDR_W    = 8,
    parameter int unsigned          DATA_W    = 8,
    parameter logic [ADDR_W-1:0]    CTRL_ADDR = 8'h8E,
    parameter int unsigned          DIS_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ale_off_o
);
    logic hit;
    logic ale_off_q;

    assign hit       = we_i && (addr_i == CTRL_ADDR);
    assign ale_off_o = ale_off_q;

    always_ff @(posedge clk) begin
        if (rst)
            ale_off_q <= 1'b0;
        else if (hit)
            ale_off_q <= wdata_i[DIS_BIT];
    end

    // R6: only an addressed write changes the disable bit
    p_ctrl_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(ale_off_o));
    p_ctrl_load_r6: assert property (@(posedge clk) disable iff (rst)
        hit |=> (ale_off_o == $past(wdata_i[DIS_BIT])));

endmodule

// File: rtl/bstb_ctx_latch.sv
module bstb_ctx_latch
    import bus_strobe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cyc_end_i,
    input  logic     xdata_i,
    input  logic     code_rd_i,
    input  logic     ext_exec_i,
    input  logic     ale_off_i,
    output cyc_ctx_t ctx_o
);
    cyc_ctx_t ctx_q;
    cyc_ctx_t ctx_d;

    always_comb begin
        ctx_d.xdata    = xdata_i;
        ctx_d.code_rd  = code_rd_i;
        ctx_d.ext_exec = ext_exec_i;
        ctx_d.ale_off  = ale_off_i;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctx_q <= CTX_RESET;
        else if (cyc_end_i)
            ctx_q <= ctx_d;
    end

    assign ctx_o = ctx_q;

    // R10: the cycle context never moves inside a machine cycle
    p_ctx_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !cyc_end_i |=> $stable(ctx_o));

endmodule

// File: rtl/bstb_decode.sv
module bstb_decode
    import bus_strobe_pkg::*;
#(
    parameter int unsigned N_STATES     = 6,
    parameter int unsigned PH_PER_STATE = 2,
    parameter int unsigned PHASES       = N_STATES * PH_PER_STATE,
    parameter int unsigned PH_W         = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] phase_i,
    input  cyc_ctx_t        ctx_i,
    output logic            ale_o,
    output logic            psen_n_o
);
    localparam int unsigned HALF = N_STATES / 2;

    logic [PHASES-1:0] ale_slot;
    logic [PHASES-1:0] psen_slot;
    logic [PHASES-1:0] first_half;

    for (genvar p = 0; p < PHASES; p++) begin : g_slot
        localparam int unsigned ST   = p / PH_PER_STATE;
        localparam slot_e       KIND = slot_of_state(ST, HALF);
        assign ale_slot[p]   = (KIND == SLOT_ALE);
        assign psen_slot[p]  = (KIND == SLOT_PSEN);
        assign first_half[p] = (ST < HALF);
    end

    logic ale_d;
    logic psen_n_d;
    logic ale_q;
    logic psen_n_q;

    always_comb begin
        if (!ale_allowed(ctx_i))
            ale_d = 1'b1;
        else
            ale_d = ale_slot[phase_i] && !(ctx_i.xdata && first_half[phase_i]);
        psen_n_d = !(psen_allowed(ctx_i) && psen_slot[phase_i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q    <= 1'b0;
            psen_n_q <= 1'b1;
        end else begin
            ale_q    <= ale_d;
            psen_n_q <= psen_n_d;
        end
    end

    assign ale_o    = ale_q;
    assign psen_n_o = psen_n_q;

    // R4: internal execution never produces a PSEN strobe
    p_int_no_psen_r4: assert property (@(posedge clk) disable iff (rst)
        !ctx_i.ext_exec |=> psen_n_o);
    // R5: a data transfer cycle drops its first ALE pulse and all PSEN pulses
    p_xdata_skip_ale_r5: assert property (@(posedge clk) disable iff (rst)
        (ctx_i.xdata && first_half[phase_i]) |=> !ale_o);
    p_xdata_no_psen_r5: assert property (@(posedge clk) disable iff (rst)
        ctx_i.xdata |=> psen_n_o);
    // R7: disabled ALE with no override sits high
    p_ale_held_r7: assert property (@(posedge clk) disable iff (rst)
        !ale_allowed(ctx_i) |=> ale_o);
    // R3: ALE and PSEN are never active together
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(ale_o && !psen_n_o));

endmodule

// File: rtl/ext_bus_strobe.sv
module ext_bus_strobe
    import bus_strobe_pkg::*;
#(
    parameter int unsigned       N_STATES     = 6,
    parameter int unsigned       PH_PER_STATE = 2,
    parameter int unsigned       ADDR_W       = 8,
    parameter int unsigned       DATA_W       = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR    = 8'h8E,
    parameter int unsigned       DIS_BIT      = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xdata_cyc_i,
    input  logic              code_rd_i,
    input  logic              ext_exec_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic              ale_o,
    output logic              psen_n_o
);
    localparam int unsigned PHASES = N_STATES * PH_PER_STATE;
    localparam int unsigned PH_W   = $clog2(PHASES);

    logic [PH_W-1:0] phase;
    logic            cyc_end;
    logic            ale_off;
    cyc_ctx_t        ctx;

    bstb_phase_ctr #(
        .PHASES (PHASES),
        .PH_W   (PH_W)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .phase_o   (phase),
        .cyc_end_o (cyc_end)
    );

    bstb_ctrl_reg #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_ADDR (CTRL_ADDR),
        .DIS_BIT   (DIS_BIT)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .we_i      (reg_we_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .ale_off_o (ale_off)
    );

    bstb_ctx_latch u_ctx (
        .clk        (clk),
        .rst        (rst),
        .cyc_end_i  (cyc_end),
        .xdata_i    (xdata_cyc_i),
        .code_rd_i  (code_rd_i),
        .ext_exec_i (ext_exec_i),
        .ale_off_i  (ale_off),
        .ctx_o      (ctx)
    );

    bstb_decode #(
        .N_STATES     (N_STATES),
        .PH_PER_STATE (PH_PER_STATE),
        .PHASES       (PHASES),
        .PH_W         (PH_W)
    ) u_dec (
        .clk      (clk),
        .rst      (rst),
        .phase_i  (phase),
        .ctx_i    (ctx),
        .ale_o    (ale_o),
        .psen_n_o (psen_n_o)
    );

    // R11: reset leaves both strobes inactive
    p_reset_idle_r11: assert property (@(posedge clk)
        rst |=> (!ale_o && psen_n_o));

endmodule

// File: tb/test_ext_bus_strobe.sv
module test_ext_bus_strobe;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xdata_cyc = 1'b0;
    logic       code_rd = 1'b0;
    logic       ext_exec = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       ale;
    logic       psen_n;

    int tests_run = 0;
    int tests_failed = 0;
    int edges = 0;
    bit bench_dis = 1'b0;

    always #2.5 clk = ~clk;

    ext_bus_strobe i_ext_bus_strobe (
        .clk         (clk),
        .rst         (rst),
        .xdata_cyc_i (xdata_cyc),
        .code_rd_i   (code_rd),
        .ext_exec_i  (ext_exec),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .ale_o       (ale),
        .psen_n_o    (psen_n)
    );

    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    // Expected strobes from the requirements (R2, R3, R5, R7, R8, R9)
    function automatic logic exp_ale(logic xd, logic cr, logic ex, logic dis, int p);
        if (dis && !xd && !cr && !ex) return 1'b1;
        if (p == 0 || p == 1) return !xd;
        return (p == 6 || p == 7);
    endfunction

    function automatic logic exp_psen_n(logic xd, logic ex, int p);
        if (ex && !xd && (p == 2 || p == 3 || p == 8 || p == 9)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // One machine cycle: set flags, wait for the boundary edge (R10), then check all 12 phases (R1)
    task automatic run_mc(logic xd, logic cr, logic ex, bit mid, string req);
        @(negedge clk);
        xdata_cyc = xd; code_rd = cr; ext_exec = ex;
        do begin
            @(posedge clk); #1;
        end while (edges % 12 != 0);
        for (int p = 0; p < 12; p++) begin
            @(posedge clk);
            @(negedge clk);
            check(req, $sformatf("ale phase %0d", p), ale, exp_ale(xd, cr, ex, bench_dis, p));
            check(req, $sformatf("psen_n phase %0d", p), psen_n, exp_psen_n(xd, ex, p));
            if (mid && p == 4) begin
                xdata_cyc = ~xd; ext_exec = ~ex; code_rd = ~cr;
            end
        end
    endtask

    task automatic reg_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a == 8'h8E) bench_dis = d[0];
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        ext_exec = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", "ale in reset", ale, 1'b0);
        check("R11", "psen_n in reset", psen_n, 1'b1);
        ext_exec = 1'b0;
        rst = 1'b0;
    endtask

    task automatic t_internal();   run_mc(1'b0, 1'b0, 1'b0, 1'b0, "R2/R4"); endtask
    task automatic t_external();   run_mc(1'b0, 1'b0, 1'b1, 1'b0, "R3");    endtask
    task automatic t_xdata();
        run_mc(1'b1, 1'b0, 1'b1, 1'b0, "R5");
        run_mc(1'b1, 1'b0, 1'b0, 1'b0, "R5");
    endtask

    task automatic t_disable();
        reg_write(8'h8E, 8'h01);
        run_mc(1'b0, 1'b0, 1'b0, 1'b0, "R6/R7");
        run_mc(1'b0, 1'b1, 1'b0, 1'b0, "R8");
        run_mc(1'b1, 1'b0, 1'b0, 1'b0, "R8");
        run_mc(1'b0, 1'b0, 1'b1, 1'b0, "R9");
    endtask

    task automatic t_addr_decode();
        reg_write(8'h8F, 8'h00);
        reg_write(8'h0E, 8'h00);
        run_mc(1'b0, 1'b0, 1'b0, 1'b0, "R6 other address ignored");
        reg_write(8'h8E, 8'hFE);
        run_mc(1'b0, 1'b0, 1'b0, 1'b0, "R6 bit 0 cleared");
    endtask

    task automatic t_midcycle();
        run_mc(1'b0, 1'b0, 1'b1, 1'b1, "R10");
        run_mc(1'b1, 1'b0, 1'b0, 1'b1, "R10");
    endtask

    task automatic t_reset_clears();
        reg_write(8'h8E, 8'h01);
        run_mc(1'b0, 1'b0, 1'b0, 1'b0, "R7");
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11", "ale in second reset", ale, 1'b0);
        check("R11", "psen_n in second reset", psen_n, 1'b1);
        rst = 1'b0;
        bench_dis = 1'b0;
        run_mc(1'b0, 1'b0, 1'b0, 1'b0, "R11 disable cleared");
    endtask

    initial begin
        #(5.0 * 200000);
        tests_failed++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        t_reset_state();
        t_internal();
        t_external();
        t_xdata();
        t_disable();
        t_addr_decode();
        t_midcycle();
        t_reset_clears();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule